// File: doc/BRIEF.md
# Decade Counter Stage with Seven-Segment Drive

This block is one digit of a decimal display chain. A counter steps through the digits zero to nine, one step for each rising clock edge. The current digit is decoded straight into seven active-high segment lines for a common-cathode display, so no separate decoder is needed between the counter and the LEDs.

Three controls shape its behaviour. A hold input freezes the count so that clock edges are ignored. A display-enable input blanks all segments when low and leaves the count running underneath. That enable is also passed on one clock later through a registered output, so a row of stages can hand the blanking control down the chain. A carry output is high for the lower half of the cycle and low for the upper half, which gives a square wave at one tenth of the clock rate. It can clock or enable the next digit. With some reset logic, two stages make the hours or minutes field of a clock.

Top module: `dseg_stage`

## Requirements
- R1: With `rst` and `hold` low, each rising clock edge raises the count by exactly one, within the range 0 to 9.
- R2: One rising edge with the count at 9 and `hold` low brings the count to 0.
- R3: With `disp_en` high, `seg` shows the current digit. Bit 0 is segment a and bit 6 is segment g. The patterns are: 0=abcdef (0x3F), 1=bc (0x06), 2=abdeg (0x5B), 3=abcdg (0x4F), 4=bcfg (0x66), 5=acdfg (0x6D), 6=acdefg (0x7D), 7=abc (0x07), 8=abcdefg (0x7F), 9=abcdfg (0x6F).
- R4: While `hold` is high, clock edges leave the count unchanged.
- R5: While `disp_en` is low, `seg` is 0x00 in the same cycle. The count keeps advancing, and the advanced digit appears as soon as `disp_en` returns high.
- R6: `carry` is high while the count is 0 to 4 and low while it is 5 to 9.
- R7: `disp_en_out` takes the value `disp_en` had at the previous rising edge. It is 0 after a reset edge.
- R8: A rising edge with `rst` high sets the count to 0. This takes priority over `hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Freezes the count when high |
| disp_en | input | 1 | Lights the segments when high and blanks them when low |
| seg | output | 7 | Segment drive, active high, bit 0 = a through bit 6 = g |
| carry | output | 1 | High for digits 0 to 4 and low for 5 to 9 |
| disp_en_out | output | 1 | `disp_en` delayed by one clock, for the next stage |

## Verification
The bench drives the counter through more than one full cycle and compares every digit's segment pattern. A stage that wrapped at the wrong digit would show a stray pattern or a skipped zero right after nine. The bench blanks the display over several edges and then re-enables it. A design that gated the count along with the segments would come back showing the old digit. The bench asserts reset while hold is high, so a reset that lost to hold would leave the count where it was. It also tracks carry across the 4-to-5 and 9-to-0 boundaries, where an off-by-one split would shift the edge by a digit.

// File: rtl/dseg_pkg.sv
package dseg_pkg;

    localparam int DIGITS     = 10;
    localparam int CNT_W      = $clog2(DIGITS);
    localparam int SEG_W      = 7;
    localparam int EN_STAGES  = 1;

    typedef logic [CNT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef struct packed {
        logic hold;
        logic rst;
    } cnt_ctrl_t;

    typedef struct packed {
        digit_t digit;
        logic   carry;
    } cnt_state_t;

    // Segment order: bit 0 = a ... bit 6 = g, active high.
    function automatic seg_t digit_to_seg(digit_t d);
        seg_t s;
        case (d)
            digit_t'(0): s = 7'h3F;
            digit_t'(1): s = 7'h06;
            digit_t'(2): s = 7'h5B;
            digit_t'(3): s = 7'h4F;
            digit_t'(4): s = 7'h66;
            digit_t'(5): s = 7'h6D;
            digit_t'(6): s = 7'h7D;
            digit_t'(7): s = 7'h07;
            digit_t'(8): s = 7'h7F;
            digit_t'(9): s = 7'h6F;
            default:     s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dseg_count.sv
module dseg_count
    import dseg_pkg::*;
#(
    parameter int MODULUS = DIGITS
) (
    input  logic       clk,
    input  cnt_ctrl_t  ctrl,
    output cnt_state_t state
);

    localparam digit_t LAST = digit_t'(MODULUS - 1);
    localparam digit_t HALF = digit_t'(MODULUS / 2);

    digit_t cnt_q;

    always_ff @(posedge clk) begin
        if (ctrl.rst) begin
            cnt_q <= '0;
        end else if (!ctrl.hold) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + digit_t'(1);
        end
    end

    always_comb begin
        state.digit = cnt_q;
        state.carry = (cnt_q < HALF);
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (ctrl.rst)
        cnt_q <= LAST);                                                   // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (ctrl.rst)
        (!ctrl.hold && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + digit_t'(1)); // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (ctrl.rst)
        (!ctrl.hold && cnt_q == LAST) |=> cnt_q == '0);                   // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (ctrl.rst)
        ctrl.hold |=> $stable(cnt_q));                                    // R4
    AST_CNT_RESET: assert property (@(posedge clk)
        ctrl.rst |=> cnt_q == '0);                                        // R8
    AST_CARRY_FALL: assert property (@(posedge clk) disable iff (ctrl.rst)
        $fell(state.carry) |-> cnt_q == HALF);                            // R6

endmodule

// File: rtl/dseg_decode.sv
module dseg_decode
    import dseg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  digit_t digit,
    input  logic   enable,
    output seg_t   seg
);

    seg_t pattern;

    always_comb begin
        pattern = digit_to_seg(digit);
        seg     = enable ? pattern : '0;
    end

    AST_SEG_LIT: assert property (@(posedge clk) disable iff (rst)
        enable |-> seg != '0);                                            // R3
    AST_SEG_SEGA_ONE: assert property (@(posedge clk) disable iff (rst)
        (enable && digit == digit_t'(1)) |-> $countones(seg) == 2);       // R3

endmodule

// File: rtl/dseg_en_delay.sv
module dseg_en_delay
    import dseg_pkg::*;
#(
    parameter int STAGES = EN_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic en_in,
    output logic en_out
);

    logic [STAGES:0] chain;

    assign chain[0] = en_in;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i+1] <= 1'b0;
            else     chain[i+1] <= chain[i];
        end

        AST_EN_FOLLOW: assert property (@(posedge clk)
            !rst |=> chain[i+1] == $past(chain[i]));                      // R7
        AST_EN_CLEAR: assert property (@(posedge clk)
            rst |=> !chain[i+1]);                                         // R7
    end

    assign en_out = chain[STAGES];

endmodule

// File: rtl/dseg_stage.sv
module dseg_stage
    import dseg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       disp_en,
    output logic [6:0] seg,
    output logic       carry,
    output logic       disp_en_out
);

    cnt_ctrl_t  ctrl;
    cnt_state_t state;
    seg_t       seg_w;

    assign ctrl.rst  = rst;
    assign ctrl.hold = hold;

    dseg_count #(.MODULUS(DIGITS)) u_count (
        .clk   (clk),
        .ctrl  (ctrl),
        .state (state)
    );

    dseg_decode u_decode (
        .clk    (clk),
        .rst    (rst),
        .digit  (state.digit),
        .enable (disp_en),
        .seg    (seg_w)
    );

    dseg_en_delay #(.STAGES(EN_STAGES)) u_en_delay (
        .clk    (clk),
        .rst    (rst),
        .en_in  (disp_en),
        .en_out (disp_en_out)
    );

    assign seg   = seg_w;
    assign carry = state.carry;

    AST_BLANK_PORT: assert property (@(posedge clk) disable iff (rst)
        !disp_en |-> seg == 7'h00);                                       // R5

endmodule

// File: tb/dseg_stage_tb.sv
module dseg_stage_tb_top;

    typedef struct {
        logic [6:0] seg;
        logic       carry;
        logic       eno;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hold = 1'b0;
    logic       disp_en = 1'b1;
    logic [6:0] seg;
    logic       carry;
    logic       disp_en_out;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt = 0;
    logic m_eno = 1'b0;
    exp_t sb_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    dseg_stage dut_i (
        .clk         (clk),
        .rst         (rst),
        .hold        (hold),
        .disp_en     (disp_en),
        .seg         (seg),
        .carry       (carry),
        .disp_en_out (disp_en_out)
    );

    function automatic logic [6:0] ref_seg(int d);
        case (d)
            0: return 7'h3F;
            1: return 7'h06;
            2: return 7'h5B;
            3: return 7'h4F;
            4: return 7'h66;
            5: return 7'h6D;
            6: return 7'h7D;
            7: return 7'h07;
            8: return 7'h7F;
            9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    // Driver: set inputs away from the edge, advance the model, queue expectation.
    task automatic step(input logic r, input logic h, input logic e, input string tag);
        exp_t x;
        @(negedge clk);
        rst = r; hold = h; disp_en = e;
        if (r) begin
            m_cnt = 0;
            m_eno = 1'b0;
        end else begin
            if (!h) m_cnt = (m_cnt + 1) % 10;
            m_eno = e;
        end
        x.seg   = e ? ref_seg(m_cnt) : 7'h00;
        x.carry = (m_cnt < 5);
        x.eno   = m_eno;
        x.tag   = tag;
        sb_q.push_back(x);
    endtask

    // Monitor: compare just after each edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t x;
            x = sb_q.pop_front();
            n_cmp++;
            if (seg !== x.seg || carry !== x.carry || disp_en_out !== x.eno) begin
                n_bad++;
                $display("FAIL %s: seg=%h carry=%b en_out=%b expected seg=%h carry=%b en_out=%b",
                         x.tag, seg, carry, disp_en_out, x.seg, x.carry, x.eno);
            end
        end
    end

    initial begin
        // R8 reset state, also with hold high (priority)
        step(1, 0, 1, "R8");
        step(1, 1, 1, "R8");
        // R1 R3 R6: walk all ten digits, R2 wrap through zero
        for (int i = 0; i < 12; i++) step(0, 0, 1, "R1_R2_R3_R6");
        // R4 hold over several edges
        for (int i = 0; i < 4; i++) step(0, 1, 1, "R4");
        step(0, 0, 1, "R1");
        // R5 blanking while counting, R7 en_out follows
        for (int i = 0; i < 3; i++) step(0, 0, 0, "R5_R7");
        step(0, 1, 0, "R5");
        step(0, 1, 1, "R5_R7");
        // R7 toggling enable each cycle
        for (int i = 0; i < 6; i++) step(0, 0, logic'(i % 2), "R7");
        // R8 reset mid-count under hold
        step(0, 0, 1, "R1");
        step(1, 1, 1, "R8");
        step(0, 0, 1, "R1");
        // R6 carry across two full cycles
        for (int i = 0; i < 20; i++) step(0, 0, 1, "R6_R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule